// File: doc/BRIEF.md
# Receive Built-In Self-Test Pattern Checker

This block sits on one receive channel after character decoding and checks a known test pattern arriving over the link. Once enabled, it looks for a start marker: a special character with a fixed code. After the marker it compares each following received character against an expected value from a local linear-feedback shift register. For every character it takes in, it produces a 3-bit status code together with a valid strobe, one clock later.

A pass is a fixed number of compared characters. On the last compare of a pass the block reports whether the whole pass was clean or had at least one bad character. It then waits for the next start marker. Loss of PLL lock pushes the checker back to its start state, and so does dropping the enable. While the enable is low, no status is produced.

Top module: `rx_bist_checker`

## Requirements
- R1: While reset is high, and on the first sampled cycle after it is released, `bist_status_vld` is 0.
- R2: Each character presented with `rx_vld` high while `bist_en` is high gives exactly one status on `bist_status`, with `bist_status_vld` high on the next clock edge. No status is produced without such a character.
- R3: The code 3'b011 is never reported.
- R4: Code 3'b101 is reported for the first character after the checker enters its start state. Enable going high and lock returning both put it in that state. While `pll_locked` is low, every character reports 3'b101 and the checker returns to the start state.
- R5: While waiting, every character reports 3'b111. This includes the start marker itself, which is `rx_special`=1 with `rx_data`=8'hBC. A character with code 8'hBC but `rx_special`=0 is not a marker. The expected-value generator stays frozen while waiting, so the first compare after a marker always expects the seed.
- R6: Compared characters expect values from an 8-bit LFSR with polynomial x^8+x^6+x^5+x^4+1. It is reloaded with seed 8'h01 at the marker and advanced once per compared character. Next value = {q[6:0], q[7]^q[5]^q[4]^q[3]}. A match reports 3'b000.
- R7: A compared character that differs in any bit, or that has `rx_special`=1, reports 3'b110.
- R8: The 511th compare after a marker reports 3'b010 if all 511 compares matched and 3'b100 otherwise, including when only that last character differs. The next character then reports 3'b111.
- R9: The error record is cleared at each start marker, so a clean pass after a bad one ends with 3'b010.
- R10: While `bist_en` is low, `bist_status_vld` stays 0. After re-enabling, the first character reports 3'b101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bist_en | input | 1 | Self-test enable |
| pll_locked | input | 1 | Receive PLL lock indication |
| rx_vld | input | 1 | Received character valid |
| rx_data | input | 8 | Decoded received character |
| rx_special | input | 1 | Character is a special (control) code |
| bist_status | output | 3 | Status code for the last accepted character |
| bist_status_vld | output | 1 | Status valid strobe |

## Verification
Every status is due exactly one clock edge after its character is accepted. The bench drives each character on a falling edge and queues its expected code at the same moment. The monitor samples on the following falling edge, when the registered output has settled, and pops one entry for each strobe it sees. A strobe with nothing queued fails R2, as does an entry still queued at the end. The pass verdict falls on the 511th compare, so the expected model counts compares itself. The bench waits two idle cycles before dropping enable or lock, so the result still in flight is not lost.

// File: rtl/bist_pkg.sv
package bist_pkg;
    localparam int CHR_W = 8;

    localparam logic [2:0] ST_MATCH    = 3'b000;
    localparam logic [2:0] ST_LASTGOOD = 3'b010;
    localparam logic [2:0] ST_RESERVED = 3'b011;
    localparam logic [2:0] ST_LASTBAD  = 3'b100;
    localparam logic [2:0] ST_STARTUP  = 3'b101;
    localparam logic [2:0] ST_MISMATCH = 3'b110;
    localparam logic [2:0] ST_WAITING  = 3'b111;

    typedef enum logic [1:0] {
        PH_START,
        PH_WAIT,
        PH_CMP
    } phase_e;

    typedef struct packed {
        logic [2:0] code;
        logic       vld;
    } status_t;

    function automatic logic [CHR_W-1:0] lfsr_step(input logic [CHR_W-1:0] q);
        return {q[6:0], q[7] ^ q[5] ^ q[4] ^ q[3]};
    endfunction
endpackage

// File: rtl/bist_lfsr.sv
module bist_lfsr
    import bist_pkg::*;
#(
    parameter logic [CHR_W-1:0] SEED = 8'h01
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             adv,
    output logic [CHR_W-1:0] expect_q
);
    logic [CHR_W-1:0] reg_q;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            reg_q <= SEED;
        end else if (adv) begin
            reg_q <= lfsr_step(reg_q);
        end
    end

    assign expect_q = reg_q;

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
        reg_q != '0);  // R6
endmodule

// File: rtl/bist_seq_ctrl.sv
module bist_seq_ctrl
    import bist_pkg::*;
#(
    parameter int SEQ_LEN = 511
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    bist_en,
    input  logic    pll_locked,
    input  logic    chr_vld,
    input  logic    is_marker,
    input  logic    match,
    output logic    lfsr_load,
    output logic    lfsr_adv,
    output status_t stat
);
    localparam int CNT_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SEQ_LEN - 1);

    phase_e         phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q;
    logic           err_q;
    logic [2:0]     code_d;
    logic           step;
    logic           at_last;

    assign step    = chr_vld && bist_en;
    assign at_last = (cnt_q == LAST_IDX);

    always_comb begin
        phase_d   = phase_q;
        code_d    = ST_STARTUP;
        lfsr_load = 1'b0;
        lfsr_adv  = 1'b0;
        if (!pll_locked) begin
            phase_d = PH_START;
            code_d  = ST_STARTUP;
        end else begin
            unique case (phase_q)
                PH_START: begin
                    code_d = ST_STARTUP;
                    if (step) phase_d = PH_WAIT;
                end
                PH_WAIT: begin
                    code_d = ST_WAITING;
                    if (step && is_marker) begin
                        phase_d   = PH_CMP;
                        lfsr_load = 1'b1;
                    end
                end
                PH_CMP: begin
                    code_d   = match ? ST_MATCH : ST_MISMATCH;
                    lfsr_adv = step;
                    if (at_last) begin
                        code_d = (err_q || !match) ? ST_LASTBAD : ST_LASTGOOD;
                        if (step) phase_d = PH_WAIT;
                    end
                end
                default: phase_d = PH_START;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !bist_en) begin
            phase_q  <= PH_START;
            cnt_q    <= '0;
            err_q    <= 1'b0;
            stat.vld <= 1'b0;
            stat.code <= ST_STARTUP;
        end else begin
            stat.vld <= chr_vld;
            if (chr_vld) stat.code <= code_d;
            if (!pll_locked) begin
                phase_q <= PH_START;
            end else if (chr_vld) begin
                phase_q <= phase_d;
                if (lfsr_load) begin
                    cnt_q <= '0;
                    err_q <= 1'b0;
                end else if (phase_q == PH_CMP) begin
                    cnt_q <= at_last ? '0 : cnt_q + 1'b1;
                    err_q <= err_q || !match;
                end
            end
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_IDX);  // R8
    AST_VERDICT_TO_WAIT: assert property (@(posedge clk) disable iff (rst)
        (stat.vld && (stat.code == ST_LASTGOOD || stat.code == ST_LASTBAD) && bist_en && pll_locked)
            |-> phase_q == PH_WAIT);  // R8
endmodule

// File: rtl/rx_bist_checker.sv
module rx_bist_checker
    import bist_pkg::*;
#(
    parameter int               SEQ_LEN    = 511,
    parameter logic [CHR_W-1:0] SEED       = 8'h01,
    parameter logic [CHR_W-1:0] START_CODE = 8'hBC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bist_en,
    input  logic             pll_locked,
    input  logic             rx_vld,
    input  logic [CHR_W-1:0] rx_data,
    input  logic             rx_special,
    output logic [2:0]       bist_status,
    output logic             bist_status_vld
);
    logic [CHR_W-1:0] expect_q;
    logic             lfsr_load;
    logic             lfsr_adv;
    logic             is_marker;
    logic             match;
    status_t          stat;

    assign is_marker = rx_special && (rx_data == START_CODE);
    assign match     = !rx_special && (rx_data == expect_q);

    bist_lfsr #(.SEED(SEED)) u_lfsr (
        .clk      (clk),
        .rst      (rst),
        .load     (lfsr_load),
        .adv      (lfsr_adv),
        .expect_q (expect_q)
    );

    bist_seq_ctrl #(.SEQ_LEN(SEQ_LEN)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .bist_en    (bist_en),
        .pll_locked (pll_locked),
        .chr_vld    (rx_vld),
        .is_marker  (is_marker),
        .match      (match),
        .lfsr_load  (lfsr_load),
        .lfsr_adv   (lfsr_adv),
        .stat       (stat)
    );

    assign bist_status     = stat.code;
    assign bist_status_vld = stat.vld;

    AST_NO_RESERVED: assert property (@(posedge clk) disable iff (rst)
        bist_status_vld |-> bist_status != ST_RESERVED);  // R3
    AST_UNLOCK_STARTUP: assert property (@(posedge clk) disable iff (rst)
        (rx_vld && bist_en && !pll_locked) |=> (!bist_en || (bist_status_vld && bist_status == ST_STARTUP)));  // R4
    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
        !bist_en |=> !bist_status_vld);  // R10
    AST_ONE_CYCLE_STATUS: assert property (@(posedge clk) disable iff (rst)
        (rx_vld && bist_en) |=> (bist_status_vld || !bist_en));  // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !rx_vld |=> !bist_status_vld);  // R2
endmodule

// File: tb/rx_bist_checker_test.sv
module rx_bist_checker_test;
    localparam int CLK_PERIOD = 10;
    localparam int SEQ = 511;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bist_en = 1'b0;
    logic       pll_locked = 1'b1;
    logic       rx_vld = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_special = 1'b0;
    logic [2:0] bist_status;
    logic       bist_status_vld;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [2:0] exp_q[$];
    string      tag_q[$];

    rx_bist_checker uut (
        .clk             (clk),
        .rst             (rst),
        .bist_en         (bist_en),
        .pll_locked      (pll_locked),
        .rx_vld          (rx_vld),
        .rx_data         (rx_data),
        .rx_special      (rx_special),
        .bist_status     (bist_status),
        .bist_status_vld (bist_status_vld)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] model_next(input logic [7:0] q);
        return {q[6:0], q[7] ^ q[5] ^ q[4] ^ q[3]};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: one pop per status strobe
    always @(negedge clk) begin
        if (!rst && bist_status_vld) begin
            if (exp_q.size() == 0) begin
                check(0, "R2 unexpected status", 1, 0);
            end else begin
                logic [2:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(bist_status == e, t, bist_status, e);
            end
        end
    end

    task automatic send(input logic [7:0] d, input logic sp, input logic [2:0] e, input string tag);
        @(negedge clk);
        rx_vld = 1'b1;
        rx_data = d;
        rx_special = sp;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic send_quiet(input logic [7:0] d);
        @(negedge clk);
        rx_vld = 1'b1;
        rx_data = d;
        rx_special = 1'b0;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        rx_vld = 1'b0;
        rx_special = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    // marker already sent; bad < 0 means clean pass
    task automatic run_pass(input int bad, input bit bad_sp);
        logic [7:0] q;
        bit err;
        q = 8'h01;
        err = 0;
        for (int k = 0; k < SEQ; k++) begin
            logic [7:0] d;
            logic sp;
            bit mis;
            logic [2:0] e;
            d = q;
            sp = 1'b0;
            mis = 0;
            if (k == bad) begin
                if (bad_sp) sp = 1'b1; else d = d ^ 8'h10;
                mis = 1;
            end
            err = err | mis;
            if (k == SEQ - 1) begin
                e = err ? 3'b100 : 3'b010;
                send(d, sp, e, "R8 pass verdict");
            end else begin
                e = mis ? 3'b110 : 3'b000;
                send(d, sp, e, mis ? "R7 mismatch" : "R6 match");
            end
            q = model_next(q);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(bist_status_vld == 1'b0, "R1 vld during reset", bist_status_vld, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(bist_status_vld == 1'b0, "R1 vld after reset", bist_status_vld, 0);
        bist_en = 1'b1;

        // startup then waiting; non-special BC is no marker
        send(8'h55, 1'b0, 3'b101, "R4 first after enable");
        send(8'h33, 1'b0, 3'b111, "R5 waiting");
        send(8'hBC, 1'b0, 3'b111, "R5 plain BC not marker");
        idle(5);
        send(8'h01, 1'b0, 3'b111, "R5 seed value while waiting");
        send(8'hBC, 1'b1, 3'b111, "R5 marker");
        run_pass(-1, 0);
        send(8'h01, 1'b0, 3'b111, "R8 back to waiting");

        // bad pass, then clean pass clears error
        send(8'hBC, 1'b1, 3'b111, "R5 marker");
        run_pass(100, 0);
        send(8'hBC, 1'b1, 3'b111, "R9 marker");
        run_pass(-1, 0);

        // special flag on data, mismatch on last only
        send(8'hBC, 1'b1, 3'b111, "R5 marker");
        run_pass(5, 1);
        send(8'hBC, 1'b1, 3'b111, "R5 marker");
        run_pass(SEQ - 1, 0);

        // lock loss mid-pass
        send(8'hBC, 1'b1, 3'b111, "R5 marker");
        send(8'h01, 1'b0, 3'b000, "R6 first compare");
        idle(2);
        pll_locked = 1'b0;
        send(8'h02, 1'b0, 3'b101, "R4 unlocked");
        send(8'hBC, 1'b1, 3'b101, "R4 unlocked marker");
        idle(2);
        pll_locked = 1'b1;
        send(8'h02, 1'b0, 3'b101, "R4 after relock");
        send(8'hBC, 1'b1, 3'b111, "R5 marker after relock");
        send(8'h01, 1'b0, 3'b000, "R6 restart expects seed");

        // disable
        idle(2);
        bist_en = 1'b0;
        send_quiet(8'h02);
        send_quiet(8'h04);
        @(negedge clk);
        rx_vld = 1'b0;
        check(bist_status_vld == 1'b0, "R10 silent when disabled", bist_status_vld, 0);
        bist_en = 1'b1;
        send(8'h08, 1'b0, 3'b101, "R10 restart after enable");
        send(8'hBC, 1'b1, 3'b111, "R5 marker");
        idle(4);
        check(exp_q.size() == 0, "R2 all statuses seen", exp_q.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(0, "watchdog expired", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule